// File: doc/BRIEF.md
# Exception Entry and Status Controller

This block owns the processor status word and a saved copy of that word for each privileged mode. Each cycle it looks at seven exception request lines. When it accepts one, it performs the entry sequence in a single clock edge. It switches the mode field to the exception's mode and masks interrupts. It stores the outgoing status word in the saved register of the new mode. It then issues a one-cycle link-register write request carrying the interrupted PC, together with a one-cycle PC load carrying the fixed vector offset for the next fetch.

Between exceptions, the surrounding core updates the condition flags through a flag write port and the low control byte (masks, instruction-set flag, mode) through a control write port. It reads and writes the saved status word of the current mode through a small access port. Instruction decode and the return-from-exception path belong to the surrounding core.

Top module: `exc_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `status` reads 0x000000D3 (supervisor mode, both masks set, flags and T clear). `pc_load` and `lr_we` are low, and `pc_next`, `lr_mode`, `lr_data` and `sv_rdata` are zero.
- R2: An accepted request raises `pc_load` on the next cycle with this `pc_next` offset and new mode code: reset 0x00 and 10011, undefined 0x04 and 11011, software interrupt 0x08 and 10011, prefetch abort 0x0C and 10111, data abort 0x10 and 10111, IRQ 0x18 and 10010, FIQ 0x1C and 10001. Offset 0x14 never appears.
- R3: When several requests are accepted in the same cycle, exactly one is served, in this order of precedence: reset, data abort, FIQ, prefetch abort, IRQ, undefined, software interrupt.
- R4: `req_irq` is ignored while status bit 7 (I) is 1, and `req_fiq` is ignored while status bit 6 (F) is 1. An ignored request leaves `pc_load` low and `status` unchanged.
- R5: On entry, status bit 7 (I) becomes 1 and bit 5 (T) becomes 0. Bit 6 (F) becomes 1 on FIQ entry and keeps its value on any other entry. Flags in bits 31..28 are kept, and bits 27..8 always read 0.
- R6: `lr_we` pulses in the same cycle as `pc_load`. `lr_mode` then equals the new mode field of `status`, and `lr_data` equals `pc_in` as sampled at the accepting edge. `pc_next`, `lr_mode` and `lr_data` hold their values until the next entry.
- R7: On entry, the status word from before the entry is stored in the saved register of the new mode. It can then be read on `sv_rdata` while that mode is current.
- R8: With no entry, `flag_we` loads `flag_in` into status bits 31..28 (N, Z, C, V from bit 31 down) at the next edge.
- R9: With no entry, `ctl_we` loads `ctl_in` into status bits 7..0 (I bit 7, F bit 6, T bit 5, mode bits 4..0). In a cycle that accepts an entry, the flag, control and saved-register writes are all dropped.
- R10: In a privileged mode (10001, 10010, 10011, 10111, 11011), `sv_we` writes `sv_wdata` into that mode's saved register. `sv_rdata` shows the current mode's saved register one cycle later, and a write becomes visible on the read the cycle after it lands.
- R11: In user (10000) and system (11111) mode, `sv_rdata` reads zero on the following cycle and `sv_we` has no effect on any saved register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined-instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Instruction fetch fault request |
| req_dabt | input | 1 | Data access fault request |
| req_irq | input | 1 | Standard interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| pc_in | input | ADDR_W | PC to save as return address |
| flag_we | input | 1 | Condition flag write enable |
| flag_in | input | 4 | New N, Z, C, V |
| ctl_we | input | 1 | Control byte write enable |
| ctl_in | input | 8 | New I, F, T, mode |
| sv_we | input | 1 | Saved status write enable (current mode) |
| sv_wdata | input | 32 | Saved status write data |
| sv_rdata | output | 32 | Current mode's saved status (registered) |
| status | output | 32 | Current status word |
| pc_load | output | 1 | Vector load pulse |
| pc_next | output | ADDR_W | Vector offset |
| lr_we | output | 1 | Link-register write pulse |
| lr_mode | output | 5 | Mode whose link register is written |
| lr_data | output | ADDR_W | Return address to write |

## Verification
Each request line is first raised alone, which separates the seven vector and mode pairs from one another. Stacked requests are then peeled off one at a time from the highest precedence down, so every rung of the precedence order is exposed individually. IRQ and FIQ are also raised with their mask bit set and with it clear, which shows the mask gating apart from the precedence logic. Write ports are driven in an entry cycle, in a privileged mode and in the user and system modes, which tells apart entry precedence, bank selection and the zero-read rule.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STAT_W = 32;
  localparam int MODE_W = 5;
  localparam int NSRC   = 7;
  localparam int NBANK  = 5;
  localparam int BANK_W = $clog2(NBANK);
  localparam int SEL_W  = $clog2(NSRC);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // request slots, lowest index wins
  localparam int SRC_RST  = 0;
  localparam int SRC_DABT = 1;
  localparam int SRC_FIQ  = 2;
  localparam int SRC_PABT = 3;
  localparam int SRC_IRQ  = 4;
  localparam int SRC_UND  = 5;
  localparam int SRC_SWI  = 6;

  function automatic logic [MODE_W-1:0] src_mode(logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(SRC_DABT), SEL_W'(SRC_PABT): return M_ABT;
      SEL_W'(SRC_FIQ):                    return M_FIQ;
      SEL_W'(SRC_IRQ):                    return M_IRQ;
      SEL_W'(SRC_UND):                    return M_UND;
      default:                            return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] src_vec(logic [SEL_W-1:0] s);
    case (s)
      SEL_W'(SRC_UND):  return 8'h04;
      SEL_W'(SRC_SWI):  return 8'h08;
      SEL_W'(SRC_PABT): return 8'h0C;
      SEL_W'(SRC_DABT): return 8'h10;
      SEL_W'(SRC_IRQ):  return 8'h18;
      SEL_W'(SRC_FIQ):  return 8'h1C;
      default:          return 8'h00;
    endcase
  endfunction

  function automatic logic is_priv(logic [MODE_W-1:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return BANK_W'(0);
      M_IRQ:   return BANK_W'(1);
      M_ABT:   return BANK_W'(3);
      M_UND:   return BANK_W'(4);
      default: return BANK_W'(2);
    endcase
  endfunction
endpackage

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]     req,
  input  logic             irq_mask,
  input  logic             fiq_mask,
  output logic             take,
  output logic [SEL_W-1:0] sel
);
  logic [N-1:0] live;

  always_comb begin
    live           = req;
    live[SRC_FIQ]  = req[SRC_FIQ] & ~fiq_mask;
    live[SRC_IRQ]  = req[SRC_IRQ] & ~irq_mask;
    take           = |live;
    sel            = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (live[k]) sel = SEL_W'(k);
    end
  end
endmodule

// File: rtl/exc_sv_bank.sv
module exc_sv_bank #(
  parameter int W  = 32,
  parameter int N  = 5,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  input  logic          rvalid,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) mem[k] <= '0;
      rdata <= '0;
    end else begin
      rdata <= rvalid ? mem[raddr] : '0;
      if (we) mem[waddr] <= wdata;
    end
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_reset,
  input  logic              req_undef,
  input  logic              req_swi,
  input  logic              req_pabt,
  input  logic              req_dabt,
  input  logic              req_irq,
  input  logic              req_fiq,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              flag_we,
  input  logic [3:0]        flag_in,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_in,
  input  logic              sv_we,
  input  logic [STAT_W-1:0] sv_wdata,
  output logic [STAT_W-1:0] sv_rdata,
  output logic [STAT_W-1:0] status,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_next,
  output logic              lr_we,
  output logic [MODE_W-1:0] lr_mode,
  output logic [ADDR_W-1:0] lr_data
);
  localparam int PAD_W = STAT_W - 12;

  logic [3:0]        flg_q;
  logic              i_q, f_q, t_q;
  logic [MODE_W-1:0] mode_q;

  logic [NSRC-1:0]   req_v;
  logic              take;
  logic [SEL_W-1:0]  sel;
  logic [MODE_W-1:0] new_mode;

  logic              bk_we;
  logic [BANK_W-1:0] bk_waddr;
  logic [STAT_W-1:0] bk_wdata;

  assign req_v[SRC_RST]  = req_reset;
  assign req_v[SRC_DABT] = req_dabt;
  assign req_v[SRC_FIQ]  = req_fiq;
  assign req_v[SRC_PABT] = req_pabt;
  assign req_v[SRC_IRQ]  = req_irq;
  assign req_v[SRC_UND]  = req_undef;
  assign req_v[SRC_SWI]  = req_swi;

  exc_arb #(.N(NSRC)) u_arb (
    .req      (req_v),
    .irq_mask (i_q),
    .fiq_mask (f_q),
    .take     (take),
    .sel      (sel)
  );

  assign new_mode = src_mode(sel);
  assign status   = {flg_q, {PAD_W{1'b0}}, i_q, f_q, t_q, mode_q};

  // one write port: entry save has priority over software access
  always_comb begin
    if (take) begin
      bk_we    = 1'b1;
      bk_waddr = bank_of(new_mode);
      bk_wdata = status;
    end else begin
      bk_we    = sv_we & is_priv(mode_q);
      bk_waddr = bank_of(mode_q);
      bk_wdata = sv_wdata;
    end
  end

  exc_sv_bank #(.W(STAT_W), .N(NBANK), .AW(BANK_W)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .we     (bk_we),
    .waddr  (bk_waddr),
    .wdata  (bk_wdata),
    .raddr  (bank_of(mode_q)),
    .rvalid (is_priv(mode_q)),
    .rdata  (sv_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_q   <= '0;
      i_q     <= 1'b1;
      f_q     <= 1'b1;
      t_q     <= 1'b0;
      mode_q  <= M_SVC;
      pc_load <= 1'b0;
      pc_next <= '0;
      lr_we   <= 1'b0;
      lr_mode <= '0;
      lr_data <= '0;
    end else begin
      pc_load <= take;
      lr_we   <= take;
      if (take) begin
        mode_q  <= new_mode;
        i_q     <= 1'b1;
        f_q     <= f_q | (sel == SEL_W'(SRC_FIQ));
        t_q     <= 1'b0;
        pc_next <= {{(ADDR_W-8){1'b0}}, src_vec(sel)};
        lr_mode <= new_mode;
        lr_data <= pc_in;
      end else begin
        if (flag_we) flg_q <= flag_in;
        if (ctl_we) {i_q, f_q, t_q, mode_q} <= ctl_in;
      end
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_reset,
  input logic              req_undef,
  input logic              req_swi,
  input logic              req_pabt,
  input logic              req_dabt,
  input logic              req_irq,
  input logic              req_fiq,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] sv_rdata,
  input logic              pc_load,
  input logic [ADDR_W-1:0] pc_next,
  input logic              lr_we,
  input logic [MODE_W-1:0] lr_mode
);
  logic others_irq, others_fiq;
  assign others_irq = req_reset | req_dabt | req_fiq | req_pabt | req_undef | req_swi;
  assign others_fiq = req_reset | req_dabt | req_pabt | req_irq | req_undef | req_swi;

  p_vec_legal_r2: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (pc_next != ADDR_W'('h14) && pc_next[1:0] == 2'b00 && pc_next <= ADDR_W'('h1C)));

  p_reset_wins_r3: assert property (@(posedge clk) disable iff (rst)
    req_reset |=> (pc_load && pc_next == '0 && lr_mode == M_SVC));

  p_irq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (req_irq && status[7] && !others_irq) |=> !pc_load);

  p_fiq_masked_r4: assert property (@(posedge clk) disable iff (rst)
    (req_fiq && status[6] && !others_fiq) |=> !pc_load);

  p_i_set_r5: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (status[7] && !status[5]));

  p_fiq_sets_f_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_load && lr_mode == M_FIQ) |-> status[6]);

  p_f_kept_r5: assert property (@(posedge clk) disable iff (rst)
    (pc_load && lr_mode != M_FIQ) |-> status[6] == $past(status[6]));

  p_lr_mode_r6: assert property (@(posedge clk) disable iff (rst)
    lr_we |-> (status[4:0] == lr_mode && pc_load));

  p_user_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (status[4:0] == M_USR || status[4:0] == M_SYS) |=> sv_rdata == '0);
endmodule

bind exc_ctrl exc_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_exc_ctrl.sv
module test_exc_ctrl;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
  logic req_dabt = 0, req_irq = 0, req_fiq = 0;
  logic [AW-1:0] pc_in = '0;
  logic flag_we = 0;
  logic [3:0] flag_in = '0;
  logic ctl_we = 0;
  logic [7:0] ctl_in = '0;
  logic sv_we = 0;
  logic [31:0] sv_wdata = '0;
  logic [31:0] sv_rdata, status;
  logic pc_load, lr_we;
  logic [AW-1:0] pc_next, lr_data;
  logic [4:0] lr_mode;

  exc_ctrl #(.ADDR_W(AW)) i_exc_ctrl (
    .clk(clk), .rst(rst),
    .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
    .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
    .pc_in(pc_in), .flag_we(flag_we), .flag_in(flag_in),
    .ctl_we(ctl_we), .ctl_in(ctl_in), .sv_we(sv_we), .sv_wdata(sv_wdata),
    .sv_rdata(sv_rdata), .status(status), .pc_load(pc_load), .pc_next(pc_next),
    .lr_we(lr_we), .lr_mode(lr_mode), .lr_data(lr_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // reference model state
  logic [31:0] m_stat;
  logic [31:0] m_sv [32];
  logic        m_pcl, m_lrwe;
  logic [31:0] m_pcn, m_lrd, m_svr;
  logic [4:0]  m_lrm;
  // source order: reset, dabt, fiq, pabt, irq, undef, swi
  logic [31:0] vtab [7] = '{32'h00, 32'h10, 32'h1C, 32'h0C, 32'h18, 32'h04, 32'h08};
  logic [4:0]  mtab [7] = '{5'h13, 5'h17, 5'h11, 5'h17, 5'h12, 5'h1B, 5'h13};

  function automatic bit m_priv(logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  task automatic model_step();
    int s;
    logic [4:0] om;
    logic [4:0] nm;
    om = m_stat[4:0];
    s  = -1;
    if (rst) begin
      m_stat = 32'h0000_00D3;
      for (int k = 0; k < 32; k++) m_sv[k] = '0;
      m_pcl = 0; m_lrwe = 0; m_pcn = '0; m_lrd = '0; m_lrm = '0; m_svr = '0;
      return;
    end
    m_svr = m_priv(om) ? m_sv[om] : 32'h0;
    if (req_reset) s = 0;
    else if (req_dabt) s = 1;
    else if (req_fiq && !m_stat[6]) s = 2;
    else if (req_pabt) s = 3;
    else if (req_irq && !m_stat[7]) s = 4;
    else if (req_undef) s = 5;
    else if (req_swi) s = 6;
    if (s >= 0) begin
      nm = mtab[s];
      m_sv[nm] = m_stat;
      m_pcl = 1; m_lrwe = 1; m_pcn = vtab[s]; m_lrm = nm; m_lrd = pc_in;
      m_stat[4:0] = nm;
      m_stat[7] = 1'b1;
      m_stat[5] = 1'b0;
      if (s == 2) m_stat[6] = 1'b1;
    end else begin
      m_pcl = 0; m_lrwe = 0;
      if (flag_we) m_stat[31:28] = flag_in;
      if (ctl_we) m_stat[7:0] = ctl_in;
      if (sv_we && m_priv(om)) m_sv[om] = sv_wdata;
    end
  endtask

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("status", status, m_stat);
    check("pc_load", 32'(pc_load), 32'(m_pcl));
    check("pc_next", pc_next, m_pcn);
    check("lr_we", 32'(lr_we), 32'(m_lrwe));
    check("lr_mode", 32'(lr_mode), 32'(m_lrm));
    check("lr_data", lr_data, m_lrd);
    check("sv_rdata", sv_rdata, m_svr);
  endtask

  task automatic idle();
    req_reset = 0; req_undef = 0; req_swi = 0; req_pabt = 0;
    req_dabt = 0; req_irq = 0; req_fiq = 0;
    flag_we = 0; ctl_we = 0; sv_we = 0;
  endtask

  task automatic set_ctl(logic [7:0] v);
    ctl_we = 1; ctl_in = v; tick(); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1"; rst = 1; tick(); tick(); rst = 0; tick();
    check("R1 reset status word", status, 32'h0000_00D3);

    tag = "R2"; req_undef = 1; pc_in = 32'h0000_0100; tick(); idle();
    check("R2 undef vector", pc_next, 32'h04);
    tick();
    tag = "R7"; tick();
    check("R7 saved old status in und", sv_rdata, 32'h0000_00D3);

    tag = "R9"; set_ctl(8'h10);
    tag = "R8"; flag_we = 1; flag_in = 4'hA; tick(); idle();
    check("R8 flags", status, 32'hA000_0010);
    tag = "R11"; sv_we = 1; sv_wdata = 32'hDEAD_BEEF; tick(); idle(); tick(); tick();

    tag = "R5"; req_irq = 1; pc_in = 32'h0000_2000; tick(); idle();
    check("R5 irq entry keeps F=0", status, 32'hA000_0092);
    tick();
    tag = "R4"; req_irq = 1; tick(); tick(); idle();
    tag = "R5"; req_fiq = 1; pc_in = 32'h0000_3000; tick(); idle();
    check("R5 fiq entry sets F", status, 32'hA000_00D1);
    tick();
    tag = "R4"; req_fiq = 1; req_irq = 1; tick(); tick(); idle();

    tag = "R10"; sv_we = 1; sv_wdata = 32'h1234_5678; tick(); idle(); tick(); tick();
    check("R10 fiq saved write", sv_rdata, 32'h1234_5678);
    set_ctl(8'h12); tick();
    check("R10 irq bank separate", sv_rdata, 32'hA000_0010);

    tag = "R3";
    for (int k = 0; k < 7; k++) begin
      set_ctl(8'h13);
      req_reset = (k <= 0); req_dabt = (k <= 1); req_fiq = (k <= 2);
      req_pabt = (k <= 3); req_irq = (k <= 4); req_undef = (k <= 5); req_swi = 1;
      pc_in = 32'h0000_4000 + 32'(k * 16);
      tick(); idle(); tick();
    end

    tag = "R9"; set_ctl(8'h13);
    req_swi = 1; flag_we = 1; flag_in = 4'h5; ctl_we = 1; ctl_in = 8'h10;
    sv_we = 1; sv_wdata = 32'hFFFF_FFFF; pc_in = 32'h0000_5000;
    tick(); idle(); tick(); tick();

    tag = "R11"; set_ctl(8'h1F);
    sv_we = 1; sv_wdata = 32'hCAFE_0000; tick(); idle(); tick();
    check("R11 system reads zero", sv_rdata, 32'h0);
    set_ctl(8'h13); tick();

    tag = "R6"; set_ctl(8'h13);
    req_pabt = 1; pc_in = 32'h0000_6004; tick(); idle();
    check("R6 link data", lr_data, 32'h0000_6004);
    tick();
    tag = "R2"; req_swi = 1; pc_in = 32'h0000_7008; tick(); idle(); tick();
    req_dabt = 1; tick(); idle(); tick();
    req_reset = 1; tick(); idle(); tick();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule